// File: doc/BRIEF.md
# Double-Precision to 32-bit Integer Wrapping Converter

The block takes one IEEE 754 double-precision operand per cycle. It produces the truncated integer value of that operand reduced modulo 2^32, read as a signed 32-bit word. It does not clamp values that fall outside the signed 32-bit range. Instead it keeps the low 32 bits of the exact integer, including two's-complement negation for negative inputs. It then sign-extends that word to the configured output width, XLEN, which is 32 or 64. Infinities and NaNs produce zero.

The datapath shifts the 53-bit significand, with its hidden bit, left by the unbiased exponent into a wide fixed-point window. In that window the integer word and the discarded fraction bits sit at fixed positions. One register stage sits between the operand and the result, so a result and its exception flags appear one cycle after the operand is presented with its strobe.

Top module: `dmod_cvt_w`

## Requirements
- R1: A result appears on `out_valid` exactly one clock after `in_valid` is high. `out_res` and `out_flags` change only for an accepted operand and otherwise hold their last value. After reset all outputs are zero.
- R2: Rounding is always toward zero. For example, 2.75 gives 2 and -2.75 gives -2.
- R3: The 32-bit result is the low 32 bits of the exact truncated integer, with no saturation. For example, 2^32+5 gives 5.
- R4: `out_res` is the 32-bit result sign-extended from its bit 31 to XLEN bits.
- R5: Positive infinity, negative infinity, quiet NaN and signaling NaN all give 0 with only the invalid flag set.
- R6: An operand with magnitude below 1 gives 0. Subnormals are included. The inexact flag is set unless the operand is +0 or -0, which raise no flag.
- R7: When the unbiased exponent is 84 or more, so that every one of the low 32 bits of the integer is zero, the result is 0 with the invalid flag set.
- R8: When the truncated integer lies outside [-2^31, 2^31-1], the invalid flag is set and the inexact flag is clear. The wrapped word is still delivered.
- R9: When the truncated integer is in range and nonzero fraction bits were dropped, only the inexact flag is set. An exact in-range value raises no flag.
- R10: For a negative operand the magnitude is negated in two's complement before the low 32 bits are taken. For example, -(2^32+5) gives 0xFFFFFFFB.
- R11: `out_flags` is five bits. Bit 4 is invalid, bit 0 is inexact, and bits 3 to 1 are always zero. Invalid and inexact are never set together.
- R12: The range edges are exact. -2^31 gives 0x80000000 with no flag. -2^31-0.5 gives 0x80000000 with inexact. 2^31 gives 0x80000000 with invalid. 2^31-1 gives 0x7FFFFFFF with no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 64 | Double-precision operand bits |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_res | output | XLEN | Wrapped integer, sign-extended to XLEN |
| out_flags | output | 5 | Exception flags: bit 4 invalid, bit 0 inexact |

## Verification
The bench builds two copies of the block side by side from the same stimulus: one with XLEN at 64 and one with XLEN at 32. The 64-bit copy makes the sign-extension of wrapped words observable, for example 2^31 turning into 0xFFFFFFFF80000000. The 32-bit copy shows that the bare word is identical. Directed operands cover the range edges, the exponent-83 and exponent-84 boundary, every special class and subnormals. A random stream across exponents near the integer window covers the shift positions.

// File: rtl/dmod_pkg.sv
package dmod_pkg;
    localparam int DBL_W  = 64;
    localparam int EXP_W  = 11;
    localparam int MAN_W  = 52;
    localparam int INT_W  = 32;
    localparam int FLAG_W = 5;

    localparam int SIG_W  = MAN_W + 1;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int SPAN   = INT_W + MAN_W;
    localparam int SH_W   = $clog2(SPAN);
    localparam int WIDE_W = SIG_W + SPAN;

    localparam int FLG_NV = 4;
    localparam int FLG_NX = 0;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_TINY,
        CLS_NUM,
        CLS_HUGE,
        CLS_SPECIAL
    } cls_e;

    typedef struct packed {
        logic              vld;
        logic [INT_W-1:0]  word;
        logic [FLAG_W-1:0] flags;
    } stage_t;
endpackage

// File: rtl/dmod_unpack.sv
module dmod_unpack
    import dmod_pkg::*;
(
    input  logic [DBL_W-1:0] op,
    output cls_e             cls,
    output logic             neg,
    output logic [SIG_W-1:0] sig,
    output logic [SH_W-1:0]  shamt
);
    logic [EXP_W-1:0] expf;
    logic [MAN_W-1:0] frac;
    logic [EXP_W-1:0] unb;

    assign expf = op[DBL_W-2 -: EXP_W];
    assign frac = op[MAN_W-1:0];
    assign neg  = op[DBL_W-1];
    assign sig  = {1'b1, frac};
    assign unb  = expf - EXP_W'(BIAS);

    always_comb begin
        shamt = '0;
        if (&expf) begin
            cls = CLS_SPECIAL;
        end else if (expf == '0 && frac == '0) begin
            cls = CLS_ZERO;
        end else if (expf < EXP_W'(BIAS)) begin
            cls = CLS_TINY;
        end else if (unb >= EXP_W'(SPAN)) begin
            cls = CLS_HUGE;
        end else begin
            cls   = CLS_NUM;
            shamt = unb[SH_W-1:0];
        end
    end
endmodule

// File: rtl/dmod_align.sv
module dmod_align
    import dmod_pkg::*;
(
    input  logic [SIG_W-1:0] sig,
    input  logic [SH_W-1:0]  shamt,
    output logic [INT_W-1:0] word,
    output logic             sticky,
    output logic             above
);
    logic [WIDE_W-1:0] wide;

    // one variable shift places the integer part at [SPAN-1:MAN_W]
    assign wide   = {{SPAN{1'b0}}, sig} << shamt;
    assign word   = wide[SPAN-1:MAN_W];
    assign sticky = |wide[MAN_W-1:0];
    assign above  = |wide[WIDE_W-1:SPAN];
endmodule

// File: rtl/dmod_pack.sv
module dmod_pack
    import dmod_pkg::*;
(
    input  cls_e              cls,
    input  logic              neg,
    input  logic [INT_W-1:0]  word,
    input  logic              sticky,
    input  logic              above,
    output logic [INT_W-1:0]  res,
    output logic [FLAG_W-1:0] flags
);
    logic range_bad;

    always_comb begin
        if (neg)
            range_bad = above | (word[INT_W-1] & (|word[INT_W-2:0]));
        else
            range_bad = above | word[INT_W-1];
    end

    always_comb begin
        res   = '0;
        flags = '0;
        case (cls)
            CLS_SPECIAL, CLS_HUGE: flags[FLG_NV] = 1'b1;
            CLS_TINY:              flags[FLG_NX] = 1'b1;
            CLS_NUM: begin
                res = neg ? (~word + INT_W'(1)) : word;
                if (range_bad)
                    flags[FLG_NV] = 1'b1;
                else if (sticky)
                    flags[FLG_NX] = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dmod_cvt_w.sv
module dmod_cvt_w
    import dmod_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DBL_W-1:0]  in_op,
    output logic              out_valid,
    output logic [XLEN-1:0]   out_res,
    output logic [FLAG_W-1:0] out_flags
);
    localparam int EXT_W = XLEN - INT_W;

    cls_e              cls;
    logic              neg;
    logic [SIG_W-1:0]  sig;
    logic [SH_W-1:0]   shamt;
    logic [INT_W-1:0]  word;
    logic              sticky;
    logic              above;
    logic [INT_W-1:0]  res;
    logic [FLAG_W-1:0] flags;

    stage_t st_d, st_q;

    dmod_unpack u_unpack (
        .op    (in_op),
        .cls   (cls),
        .neg   (neg),
        .sig   (sig),
        .shamt (shamt)
    );

    dmod_align u_align (
        .sig    (sig),
        .shamt  (shamt),
        .word   (word),
        .sticky (sticky),
        .above  (above)
    );

    dmod_pack u_pack (
        .cls    (cls),
        .neg    (neg),
        .word   (word),
        .sticky (sticky),
        .above  (above),
        .res    (res),
        .flags  (flags)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.word  = res;
            st_d.flags = flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_flags = st_q.flags;

    generate
        if (EXT_W > 0) begin : g_wide
            assign out_res = {{EXT_W{st_q.word[INT_W-1]}}, st_q.word};
        end else begin : g_narrow
            assign out_res = st_q.word[XLEN-1:0];
        end
    endgenerate
endmodule

// File: rtl/dmod_cvt_w_chk.sv
module dmod_cvt_w_chk
    import dmod_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DBL_W-1:0]  in_op,
    input logic              out_valid,
    input logic [XLEN-1:0]   out_res,
    input logic [FLAG_W-1:0] out_flags
);
    logic [EXP_W-1:0] expf;
    assign expf = in_op[DBL_W-2 -: EXP_W];

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_res) && $stable(out_flags)));
    assert_special_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&expf)) |=> (out_res == '0 && out_flags == 5'b10000));
    assert_tiny_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && expf < EXP_W'(BIAS)) |=> (out_res == '0 && !out_flags[FLG_NV]));
    assert_huge_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(&expf) && expf >= EXP_W'(BIAS + SPAN))
            |=> (out_res == '0 && out_flags == 5'b10000));
    assert_flag_shape_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_flags[3:1] == 3'b000
                       && !(out_flags[FLG_NV] && out_flags[FLG_NX])));

    generate
        if (XLEN > INT_W) begin : g_ext
            assert_sign_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> ((&out_res[XLEN-1:INT_W-1]) || !(|out_res[XLEN-1:INT_W-1])));
        end
    endgenerate
endmodule

bind dmod_cvt_w dmod_cvt_w_chk #(.XLEN(XLEN)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .out_valid (out_valid),
    .out_res   (out_res),
    .out_flags (out_flags)
);

// File: tb/dmod_cvt_w_tb_top.sv
module dmod_cvt_w_tb_top;
    localparam logic [4:0] NV = 5'b10000;
    localparam logic [4:0] NX = 5'b00001;
    localparam logic [4:0] NO = 5'b00000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_op = '0;
    logic        v64, v32;
    logic [63:0] r64;
    logic [31:0] r32;
    logic [4:0]  f64, f32;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit have_last = 1'b0;
    logic [63:0] last64 = '0;

    logic [36:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    dmod_cvt_w #(.XLEN(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .out_valid(v64), .out_res(r64), .out_flags(f64));

    dmod_cvt_w #(.XLEN(32)) dut32_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .out_valid(v32), .out_res(r32), .out_flags(f32));

    task automatic check(input bit ok, input string tag, input logic [63:0] got,
                         input logic [63:0] want);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, want);
        end
    endtask

    function automatic void model(input logic [63:0] x, output logic [31:0] w,
                                  output logic [4:0] f);
        logic [10:0]  ex = x[62:52];
        logic [127:0] sig = {75'd0, 1'b1, x[51:0]};
        logic [127:0] mag;
        bit lost = 0;
        int e;
        w = '0;
        f = NO;
        if (ex == 11'h7FF) f = NV;
        else if (ex < 11'd1023) f = (x[62:0] != 0) ? NX : NO;
        else begin
            e = int'(ex) - 1023;
            if (e >= 84) f = NV;
            else begin
                if (e <= 52) begin
                    mag  = sig >> (52 - e);
                    lost = (sig & ((128'd1 << (52 - e)) - 1)) != 0;
                end else mag = sig << (e - 52);
                w = x[63] ? (~mag[31:0] + 32'd1) : mag[31:0];
                if (x[63] ? (mag > 128'h8000_0000) : (mag > 128'h7FFF_FFFF)) f = NV;
                else if (lost) f = NX;
            end
        end
    endfunction

    task automatic send(input logic [63:0] op, input logic [31:0] w,
                        input logic [4:0] f, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        exp_q.push_back({w, f});
        tag_q.push_back(tag);
    endtask

    task automatic send_model(input logic [63:0] op);
        logic [31:0] w;
        logic [4:0]  f;
        model(op, w, f);
        send(op, w, f, "R3/R8/R9 random");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_op    = {$urandom, $urandom};
        end
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (v64) begin
                    logic [36:0] it;
                    string t;
                    logic [63:0] want64;
                    if (exp_q.size() == 0) begin
                        check(0, "R1 unexpected out_valid", 64'(v64), 64'd0);
                    end else begin
                        it = exp_q.pop_front();
                        t  = tag_q.pop_front();
                        want64 = {{32{it[36]}}, it[36:5]};
                        check(r64 == want64, {t, " R4 res64"}, r64, want64);
                        check(r32 == it[36:5], {t, " res32"}, 64'(r32), 64'(it[36:5]));
                        check(f64 == it[4:0] && f32 == it[4:0], {t, " R11 flags"},
                              64'(f64), 64'(it[4:0]));
                        check(v32 == 1'b1, "R1 valid32", 64'(v32), 64'd1);
                        last64    = want64;
                        have_last = 1'b1;
                    end
                end else if (have_last) begin
                    check(r64 == last64 && !v32, "R1 hold while idle", r64, last64);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!v64 && r64 == 0 && f64 == 0 && !v32 && r32 == 0, "R1 reset state",
              r64, 64'd0);

        send(64'h4006000000000000, 32'd2,          NX, "R2 +2.75");
        send(64'hC006000000000000, 32'hFFFFFFFE,   NX, "R2 -2.75");
        send(64'h3FF0000000000000, 32'd1,          NO, "R9 exact 1.0");
        idle(3);
        send(64'h41F0000000500000, 32'd5,          NV, "R3 2^32+5");
        send(64'hC1F0000000500000, 32'hFFFFFFFB,   NV, "R10 -(2^32+5)");
        send(64'h7FF0000000000000, 32'd0,          NV, "R5 +inf");
        send(64'hFFF0000000000000, 32'd0,          NV, "R5 -inf");
        send(64'h7FF8000000000000, 32'd0,          NV, "R5 qNaN");
        send(64'h7FF0000000000001, 32'd0,          NV, "R5 sNaN");
        send(64'h3FE0000000000000, 32'd0,          NX, "R6 0.5");
        send(64'h0000000000000001, 32'd0,          NX, "R6 subnormal");
        send(64'h0000000000000000, 32'd0,          NO, "R6 +0");
        send(64'h8000000000000000, 32'd0,          NO, "R6 -0");
        send(64'h4530000000000000, 32'd0,          NV, "R7 2^84");
        send(64'h4520000000000001, 32'h80000000,   NV, "R7 exp83 edge");
        send(64'h41E0000000000000, 32'h80000000,   NV, "R12 R8 2^31");
        send(64'hC1E0000000000000, 32'h80000000,   NO, "R12 -2^31");
        send(64'hC1E0000000100000, 32'h80000000,   NX, "R12 -2^31-0.5");
        send(64'h41DFFFFFFFC00000, 32'h7FFFFFFF,   NO, "R12 2^31-1");
        idle(2);
        for (int i = 0; i < 400; i++) begin
            logic [10:0] ex = 11'(1000 + $urandom_range(0, 120));
            send_model({1'($urandom), ex, $urandom, 20'($urandom)});
            if (i % 37 == 0) idle(2);
        end
        idle(4);
        done = 1'b1;
        if (exp_q.size() != 0) check(0, "R1 results missing", 64'(exp_q.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule